// File: doc/BRIEF.md
# Address-Match Patch and Breakpoint Unit

This block sits on the address path between a small processor core and its memories. Every accepted access, whether it is an instruction fetch or a data access, is compared against a bank of programmable comparators. A comparator on patch duty replaces the word address of a matching access with the entry for that comparator in a remap table, so the access is served from a patch location. A comparator on breakpoint duty leaves the address alone and raises a one-cycle breakpoint request that names the comparator. Nothing happens until a global enable bit is set.

A word-addressed configuration port holds three kinds of registers:

- a control word with the global enable, a sticky alignment-error flag, per-comparator valid bits and per-comparator duty bits;
- one match-address register per comparator;
- one remap-address register per comparator.

The compare and the selection of the winning comparator are combinational. The resulting address is registered together with the breakpoint request, so every access appears at the output one cycle after it is accepted.

Top module: `addr_patch_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_patched` and `bkpt_req` are 0. The control word and all match registers read back as 0.
- R2: The configuration port uses these word indices: 0 for control, 8+k for the match register of comparator k, and 16+k for its remap register. The control word holds enable in bit 0, the alignment-error flag in bit 1, valid of comparator k in bit 8+k, and duty of comparator k in bit 16+k (0 = patch, 1 = breakpoint). A read returns data on `cfg_rdata` one cycle after `cfg_rd`.
- R3: While the enable bit is 0, no access is patched or raises a breakpoint, and `out_addr` equals the input address.
- R4: A comparator whose valid bit is 0 never matches.
- R5: A comparator matches when bits [ADDR_W-1:2] of the access address equal its match register. Fetches (`acc_kind`=0) and data accesses (`acc_kind`=1) both match. `out_kind` echoes `acc_kind`.
- R6: A match on a patch-duty comparator gives `out_patched`=1 and an `out_addr` made of the remap word of that comparator with the access's low two bits appended.
- R7: A match on a breakpoint-duty comparator gives a `bkpt_req` pulse lasting one cycle per access, with `bkpt_idx` set to the comparator number. `out_addr` is unchanged and `out_patched` is 0. Patch and breakpoint are never signalled together.
- R8: When several comparators match, the lowest-numbered one decides both the duty and the remap entry.
- R9: A write of a match or remap value with nonzero bits [1:0] stores the value with those bits cleared and sets the sticky alignment-error flag. Only a control write with bit 1 set clears the flag.
- R10: `out_valid` is 1 exactly in the cycle after an accepted access. An access that does not match leaves `out_addr` equal to its input address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW | Configuration word index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Registered configuration read data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 1 | 0 = instruction fetch, 1 = data access |
| acc_addr | input | ADDR_W | Access byte address |
| out_valid | output | 1 | Output access valid |
| out_kind | output | 1 | Kind of the output access |
| out_addr | output | ADDR_W | Possibly remapped address |
| out_patched | output | 1 | The address was remapped |
| bkpt_req | output | 1 | Breakpoint request pulse |
| bkpt_idx | output | IDX_W | Comparator that raised the breakpoint |

## Verification
The bench builds the block with its defaults: six comparators, 32-bit addresses and a 5-bit configuration index. With these values the highest-numbered comparator (5) can be tested, as can two comparators of different duties programmed to the same address, so priority, duty selection and the valid bits can be shown apart. Byte offsets inside a matched word, misaligned table writes and both access kinds are all driven at these widths.

// File: rtl/apu_pkg.sv
package apu_pkg;
  // configuration index split: upper bits pick a group, lower bits a slot
  localparam int SLOT_W       = 3;
  localparam int GRP_CTRL     = 0;
  localparam int GRP_MATCH    = 1;
  localparam int GRP_REMAP    = 2;
  // control word fields
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ERR_BIT = 1;
  localparam int VALID_LSB    = 8;
  localparam int DUTY_LSB     = 16;

  typedef enum logic {
    DUTY_PATCH = 1'b0,
    DUTY_BREAK = 1'b1
  } duty_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MATCH,
    SEL_REMAP
  } cfg_sel_e;
endpackage

// File: rtl/apu_cfg_regs.sv
module apu_cfg_regs
  import apu_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 5,
  parameter int IDX_W   = 3,
  parameter int WORD_W  = ADDR_W - 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr,
  input  logic                           cfg_rd,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [ADDR_W-1:0]              cfg_rdata,
  output logic                           glb_en,
  output logic                           align_err,
  output logic [NUM_CMP-1:0]             cmp_valid,
  output logic [NUM_CMP-1:0]             cmp_duty,
  output logic [NUM_CMP-1:0][WORD_W-1:0] match_tbl,
  input  logic [IDX_W-1:0]               rmp_idx,
  output logic [WORD_W-1:0]              rmp_word
);
  localparam int GRP_W = CFG_AW - SLOT_W;

  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  sidx;
  logic              slot_ok;
  cfg_sel_e          sel;
  logic              tbl_wr;
  logic              wr_misal;
  logic [WORD_W-1:0] wr_word;
  logic [ADDR_W-1:0] ctrl_view;

  // remap table: written synchronously, no reset, so it maps onto a RAM
  logic [WORD_W-1:0] remap_mem [NUM_CMP];

  assign grp     = cfg_addr[CFG_AW-1:SLOT_W];
  assign slot    = cfg_addr[SLOT_W-1:0];
  assign sidx    = slot[IDX_W-1:0];
  assign slot_ok = (int'(slot) < NUM_CMP);
  assign wr_word = cfg_wdata[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (grp == GRP_W'(GRP_CTRL) && slot == '0)      sel = SEL_CTRL;
    else if (grp == GRP_W'(GRP_MATCH) && slot_ok)   sel = SEL_MATCH;
    else if (grp == GRP_W'(GRP_REMAP) && slot_ok)   sel = SEL_REMAP;
  end

  assign tbl_wr   = cfg_wr && (sel == SEL_MATCH || sel == SEL_REMAP);
  assign wr_misal = tbl_wr && (cfg_wdata[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en    <= 1'b0;
      align_err <= 1'b0;
      cmp_valid <= '0;
      cmp_duty  <= '0;
      match_tbl <= '0;
    end else begin
      if (cfg_wr && sel == SEL_CTRL) begin
        glb_en    <= cfg_wdata[CTRL_EN_BIT];
        cmp_valid <= cfg_wdata[VALID_LSB +: NUM_CMP];
        cmp_duty  <= cfg_wdata[DUTY_LSB +: NUM_CMP];
        if (cfg_wdata[CTRL_ERR_BIT]) align_err <= 1'b0;
      end
      if (wr_misal) align_err <= 1'b1;
      if (cfg_wr && sel == SEL_MATCH) match_tbl[sidx] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_wr && sel == SEL_REMAP) remap_mem[sidx] <= wr_word;
  end

  assign rmp_word = remap_mem[rmp_idx];

  always_comb begin
    ctrl_view                         = '0;
    ctrl_view[CTRL_EN_BIT]            = glb_en;
    ctrl_view[CTRL_ERR_BIT]           = align_err;
    ctrl_view[VALID_LSB +: NUM_CMP]   = cmp_valid;
    ctrl_view[DUTY_LSB +: NUM_CMP]    = cmp_duty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      unique case (sel)
        SEL_CTRL:  cfg_rdata <= ctrl_view;
        SEL_MATCH: cfg_rdata <= {match_tbl[sidx], 2'b00};
        SEL_REMAP: cfg_rdata <= {remap_mem[sidx], 2'b00};
        default:   cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/apu_cmp_bank.sv
module apu_cmp_bank #(
  parameter int NUM_CMP = 6,
  parameter int IDX_W   = 3,
  parameter int WORD_W  = 30
) (
  input  logic [WORD_W-1:0]              acc_word,
  input  logic                           glb_en,
  input  logic [NUM_CMP-1:0]             cmp_valid,
  input  logic [NUM_CMP-1:0][WORD_W-1:0] match_tbl,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [NUM_CMP-1:0] eq;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign eq[k] = cmp_valid[k] && (acc_word == match_tbl[k]);
  end

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit_idx = '0;
    for (int k = NUM_CMP - 1; k >= 0; k--) begin
      if (eq[k]) hit_idx = IDX_W'(k);
    end
    any_hit = glb_en && (|eq);
  end
endmodule

// File: rtl/apu_out_stage.sv
module apu_out_stage
  import apu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              any_hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  duty_e             hit_duty,
  input  logic [WORD_W-1:0] rmp_word,
  output logic              out_valid,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_patched,
  output logic              bkpt_req,
  output logic [IDX_W-1:0]  bkpt_idx
);
  logic do_patch;
  logic do_break;

  assign do_patch = acc_valid && any_hit && (hit_duty == DUTY_PATCH);
  assign do_break = acc_valid && any_hit && (hit_duty == DUTY_BREAK);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_kind    <= 1'b0;
      out_addr    <= '0;
      out_patched <= 1'b0;
      bkpt_req    <= 1'b0;
      bkpt_idx    <= '0;
    end else begin
      out_valid   <= acc_valid;
      out_patched <= do_patch;
      bkpt_req    <= do_break;
      bkpt_idx    <= do_break ? hit_idx : '0;
      if (acc_valid) begin
        out_kind <= acc_kind;
        out_addr <= do_patch ? {rmp_word, acc_addr[1:0]} : acc_addr;
      end
    end
  end
endmodule

// File: rtl/addr_patch_unit.sv
module addr_patch_unit
  import apu_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 5,
  parameter int IDX_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              out_valid,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_patched,
  output logic              bkpt_req,
  output logic [IDX_W-1:0]  bkpt_idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic                           glb_en;
  logic                           align_err;
  logic [NUM_CMP-1:0]             cmp_valid;
  logic [NUM_CMP-1:0]             cmp_duty;
  logic [NUM_CMP-1:0][WORD_W-1:0] match_tbl;
  logic [WORD_W-1:0]              rmp_word;
  logic                           any_hit;
  logic [IDX_W-1:0]               hit_idx;
  duty_e                          hit_duty;

  apu_cfg_regs #(
    .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .glb_en(glb_en), .align_err(align_err),
    .cmp_valid(cmp_valid), .cmp_duty(cmp_duty), .match_tbl(match_tbl),
    .rmp_idx(hit_idx), .rmp_word(rmp_word)
  );

  apu_cmp_bank #(
    .NUM_CMP(NUM_CMP), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_cmp (
    .acc_word(acc_addr[ADDR_W-1:2]), .glb_en(glb_en),
    .cmp_valid(cmp_valid), .match_tbl(match_tbl),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  assign hit_duty = duty_e'(cmp_duty[hit_idx]);

  apu_out_stage #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_out (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .any_hit(any_hit), .hit_idx(hit_idx), .hit_duty(hit_duty),
    .rmp_word(rmp_word),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
    .out_patched(out_patched), .bkpt_req(bkpt_req), .bkpt_idx(bkpt_idx)
  );
endmodule

// File: rtl/apu_checker.sv
module apu_checker #(
  parameter int NUM_CMP = 6,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [1:0]        wdata_lo,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              glb_en,
  input logic              align_err,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_patched,
  input logic              bkpt_req
);
  localparam int GRP_W = CFG_AW - 3;

  logic tbl_wr;
  logic err_clr;

  assign tbl_wr  = cfg_wr
                && (cfg_addr[CFG_AW-1:3] == GRP_W'(1) || cfg_addr[CFG_AW-1:3] == GRP_W'(2))
                && (int'(cfg_addr[2:0]) < NUM_CMP);
  assign err_clr = cfg_wr && (cfg_addr == '0) && wdata_lo[1];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_patched && !bkpt_req && !glb_en && !align_err));

  assert_disabled_no_effect_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !glb_en) |=> (!out_patched && !bkpt_req && out_addr == $past(acc_addr)));

  assert_patch_xor_break_R7: assert property (@(posedge clk) disable iff (rst)
    !(out_patched && bkpt_req));

  assert_break_needs_access_R7: assert property (@(posedge clk) disable iff (rst)
    bkpt_req |-> $past(acc_valid));

  assert_misaligned_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (tbl_wr && wdata_lo != 2'b00) |=> align_err);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (align_err && !err_clr) |=> align_err);

  assert_one_cycle_latency_R10: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(acc_valid));

  assert_unpatched_passthrough_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_patched) |-> (out_addr == $past(acc_addr)));
endmodule

bind addr_patch_unit apu_checker #(
  .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)
) u_apu_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .wdata_lo(cfg_wdata[1:0]), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .glb_en(glb_en), .align_err(align_err), .out_valid(out_valid),
  .out_addr(out_addr), .out_patched(out_patched), .bkpt_req(bkpt_req)
);

// File: tb/addr_patch_unit_test.sv
`timescale 1ns/1ps
module addr_patch_unit_test;
  localparam int NUM_CMP = 6;
  localparam int ADDR_W  = 32;
  localparam int CFG_AW  = 5;
  localparam int IDX_W   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0;
  logic              cfg_rd = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic [ADDR_W-1:0] cfg_rdata;
  logic              acc_valid = 1'b0;
  logic              acc_kind = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              out_valid;
  logic              out_kind;
  logic [ADDR_W-1:0] out_addr;
  logic              out_patched;
  logic              bkpt_req;
  logic [IDX_W-1:0]  bkpt_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_patch_unit #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .out_valid(out_valid),
    .out_kind(out_kind), .out_addr(out_addr), .out_patched(out_patched),
    .bkpt_req(bkpt_req), .bkpt_idx(bkpt_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(bit en, bit err, logic [5:0] vld, logic [5:0] duty);
    return 32'(en) | (32'(err) << 1) | (32'(vld) << 8) | (32'(duty) << 16);
  endfunction

  task automatic cfg_write(input int a, input logic [31:0] d);
    cfg_addr = CFG_AW'(a); cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    cfg_addr = CFG_AW'(a); cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input bit kind);
    acc_addr = a; acc_kind = kind; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 bkpt_req", 32'(bkpt_req), 0);
    chk("R1 out_patched", 32'(out_patched), 0);
    cfg_read(0, d);  chk("R1 control", d, 0);
    cfg_read(8, d);  chk("R1 match0", d, 0);
    cfg_read(13, d); chk("R1 match5", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    cfg_write(8, 32'h0000_1000);
    cfg_write(16, 32'h0000_8000);
    cfg_write(0, ctrl_word(0, 0, 6'b000001, 6'b0));
    access(32'h1000, 0);
    chk("R3 disabled addr", out_addr, 32'h1000);
    chk("R3 disabled patched", 32'(out_patched), 0);
    cfg_write(0, ctrl_word(1, 0, 6'b000001, 6'b0));
    cfg_read(0, d); chk("R2 control readback", d, ctrl_word(1, 0, 6'b000001, 6'b0));
    cfg_read(16, d); chk("R2 remap0 readback", d, 32'h8000);
    access(32'h1000, 0);
    chk("R6 patched addr", out_addr, 32'h8000);
    chk("R6 patched flag", 32'(out_patched), 1);
    chk("R10 out_valid", 32'(out_valid), 1);
    @(negedge clk);
    chk("R10 idle out_valid", 32'(out_valid), 0);
  endtask

  task automatic t_kinds();
    access(32'h1000, 1);
    chk("R5 data access patched", out_addr, 32'h8000);
    chk("R5 out_kind", 32'(out_kind), 1);
    access(32'h1002, 0);
    chk("R5 byte offset kept", out_addr, 32'h8002);
    access(32'h1004, 1);
    chk("R10 miss passthrough", out_addr, 32'h1004);
    chk("R10 miss not patched", 32'(out_patched), 0);
  endtask

  task automatic t_break();
    cfg_write(11, 32'h0000_2000);
    cfg_write(0, ctrl_word(1, 0, 6'b001001, 6'b001000));
    access(32'h2000, 1);
    chk("R7 bkpt_req", 32'(bkpt_req), 1);
    chk("R7 bkpt_idx", 32'(bkpt_idx), 3);
    chk("R7 addr unchanged", out_addr, 32'h2000);
    chk("R7 not patched", 32'(out_patched), 0);
    @(negedge clk);
    chk("R7 pulse ends", 32'(bkpt_req), 0);
  endtask

  task automatic t_priority();
    cfg_write(9, 32'h0000_3000);
    cfg_write(17, 32'h0000_A000);
    cfg_write(12, 32'h0000_3000);
    cfg_write(0, ctrl_word(1, 0, 6'b011011, 6'b011000));
    access(32'h3000, 0);
    chk("R8 lower patch wins", out_addr, 32'hA000);
    chk("R8 no breakpoint", 32'(bkpt_req), 0);
    cfg_write(0, ctrl_word(1, 0, 6'b011001, 6'b011000));
    access(32'h3000, 0);
    chk("R8 next comparator break", 32'(bkpt_req), 1);
    chk("R8 next comparator idx", 32'(bkpt_idx), 4);
    chk("R8 addr unchanged", out_addr, 32'h3000);
  endtask

  task automatic t_valid();
    cfg_write(0, ctrl_word(1, 0, 6'b011000, 6'b011000));
    access(32'h1000, 0);
    chk("R4 invalid no patch", 32'(out_patched), 0);
    chk("R4 invalid addr", out_addr, 32'h1000);
  endtask

  task automatic t_align();
    logic [31:0] d;
    cfg_write(10, 32'h0000_5000);
    cfg_read(0, d); chk("R9 aligned write no flag", d, ctrl_word(1, 0, 6'b011000, 6'b011000));
    cfg_write(13, 32'h0000_4003);
    cfg_read(13, d); chk("R9 match low bits cleared", d, 32'h4000);
    cfg_read(0, d); chk("R9 flag set", d, ctrl_word(1, 1, 6'b011000, 6'b011000));
    cfg_write(21, 32'h0000_B001);
    cfg_read(21, d); chk("R9 remap low bits cleared", d, 32'hB000);
    cfg_write(0, ctrl_word(1, 1, 6'b100000, 6'b0));
    cfg_read(0, d); chk("R9 flag cleared", d, ctrl_word(1, 0, 6'b100000, 6'b0));
    access(32'h4001, 1);
    chk("R6 top comparator patch", out_addr, 32'hB001);
    chk("R6 top comparator flag", 32'(out_patched), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_kinds();
    t_break();
    t_priority();
    t_valid();
    t_align();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule